// File: doc/BRIEF.md
# Windowed Current-Limit Event Counter

This block watches the trip outputs of two current-limit comparators, one on the primary winding and one on the secondary winding of a switching converter. Instead of shutting the converter down on the first overcurrent trip, it counts the switching cycles in which each comparator tripped. The count runs over a fixed window of switching cycles. A side whose count reaches its own threshold before the window closes raises a fault flag. The flag stays latched until the block is cleared or re-enabled.

A switching-cycle strobe (`cycleEn`, one clock wide and once per switching period) advances the window. Both counts restart from zero whenever the window closes. The primary fault stands for fault code 1 and the secondary fault for fault code 2 in a downstream encoder. That encoder also chooses which code to report when both flags are set. An enable input holds the whole counting path idle. A clear strobe empties the counts and drops the flags.

Top module: `ilim_window_monitor`

## Requirements
- R1: The window is WIN_LEN (default 32) enabled switching cycles long, counted from the last clear or enable. At the strobe that ends a window, both event counts return to zero, so events from different windows are never added together.
- R2: `faultPri` becomes 1 in the clock after the switching strobe at which the primary count reaches PRI_LIMIT (default 4) within one window. It changes only at such a strobe.
- R3: `faultSec` becomes 1 in the clock after the switching strobe at which the secondary count reaches SEC_LIMIT (default 8) within one window. Primary events have no effect on it.
- R4: A side counts one event in a switching cycle if its limit input had at least one 0-to-1 transition during that cycle, including in the clock of the strobe itself. Several transitions in one cycle count once. A level held high across several cycles counts once.
- R5: When both thresholds are reached at the same strobe, both fault flags are set in the same clock.
- R6: A set fault flag stays 1 until `clrStrobe` is high or `enable` rises. Either one clears both flags in the following clock.
- R7: While `enable` is 0, the event counts and the window position are held at zero, limit transitions and switching strobes are ignored, and the fault flags keep their values.
- R8: `clrStrobe` high for one clock clears both flags and restarts the counts and the window. Clearing takes priority over setting in the same clock.
- R9: After reset both fault flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cycleEn | input | 1 | One-clock strobe marking the end of each switching cycle |
| enable | input | 1 | Run enable. Low holds the counting path idle; a rising edge clears the faults |
| clrStrobe | input | 1 | Synchronous clear of the faults, counts and window |
| limPri | input | 1 | Primary current-limit comparator output |
| limSec | input | 1 | Secondary current-limit comparator output |
| faultPri | output | 1 | Latched primary over-limit fault (code 1) |
| faultSec | output | 1 | Latched secondary over-limit fault (code 2) |

## Verification
The assertions assume that `cycleEn`, `enable`, `clrStrobe` and both limit inputs are synchronous to `clk` and stable around its rising edge. They also assume that reset is held for more than one clock, so the enable history the checker keeps begins from a known low level. The bench changes every input only on the falling edge. It keeps `enable` low during reset. Its random phase spaces the switching strobes and limit pulses so that windows fill up, expire and clear in many different orders.

// File: rtl/ilim_pkg.sv
package ilim_pkg;
  typedef struct packed {
    logic tick;      // enabled switching-cycle boundary
    logic winEnd;    // boundary that closes the current window
    logic flush;     // hold counts, window and pending events at zero
    logic faultClr;  // drop latched faults
  } ilimStrobe_t;

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/ilim_window_ctrl.sv
module ilim_window_ctrl
  import ilim_pkg::*;
#(
  parameter int WIN_LEN = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cycleEn,
  input  logic        enable,
  input  logic        clrStrobe,
  output ilimStrobe_t stb
);
  localparam int WW = (WIN_LEN > 1) ? $clog2(WIN_LEN) : 1;
  localparam logic [WW-1:0] LAST = WW'(WIN_LEN - 1);

  logic [WW-1:0] winCnt;
  logic          enQ;

  always_comb begin
    stb.tick     = cycleEn & enable;
    stb.flush    = ~enable | clrStrobe;
    stb.winEnd   = stb.tick && (winCnt == LAST);
    stb.faultClr = clrStrobe | (enable & ~enQ);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      winCnt <= '0;
      enQ    <= 1'b0;
    end else begin
      enQ <= enable;
      if (stb.flush)       winCnt <= '0;
      else if (stb.winEnd) winCnt <= '0;
      else if (stb.tick)   winCnt <= winCnt + 1'b1;
    end
  end
endmodule

// File: rtl/ilim_event_path.sv
module ilim_event_path
  import ilim_pkg::*;
#(
  parameter int PRI_LIMIT = 4,
  parameter int SEC_LIMIT = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  ilimStrobe_t stb,
  input  logic [1:0]  lim,
  output logic [1:0]  fault
);
  localparam int MAXLIM = maxOf(PRI_LIMIT, SEC_LIMIT);
  localparam int CW     = $clog2(MAXLIM + 1);

  for (genvar s = 0; s < 2; s++) begin : g_side
    localparam int LIM = (s == 0) ? PRI_LIMIT : SEC_LIMIT;
    localparam logic [CW:0] LIMW = (CW+1)'(LIM);

    logic          limQ;
    logic          seen;
    logic          faultQ;
    logic [CW-1:0] cnt;
    logic          edgeNow;
    logic          hit;
    logic [CW:0]   nxt;
    logic          reach;

    always_comb begin
      edgeNow = lim[s] & ~limQ;
      hit     = seen | edgeNow;
      nxt     = {1'b0, cnt} + {{CW{1'b0}}, hit};
      reach   = (nxt >= LIMW);
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        limQ   <= 1'b0;
        seen   <= 1'b0;
        cnt    <= '0;
        faultQ <= 1'b0;
      end else begin
        limQ <= lim[s];
        if (stb.flush) begin
          seen <= 1'b0;
          cnt  <= '0;
        end else if (stb.tick) begin
          seen <= 1'b0;
          if (stb.winEnd) cnt <= '0;
          else            cnt <= reach ? LIMW[CW-1:0] : nxt[CW-1:0];
        end else if (edgeNow) begin
          seen <= 1'b1;
        end
        if (stb.faultClr)            faultQ <= 1'b0;
        else if (stb.tick && reach)  faultQ <= 1'b1;
      end
    end

    assign fault[s] = faultQ;
  end
endmodule

// File: rtl/ilim_window_monitor.sv
module ilim_window_monitor
  import ilim_pkg::*;
#(
  parameter int WIN_LEN   = 32,
  parameter int PRI_LIMIT = 4,
  parameter int SEC_LIMIT = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic cycleEn,
  input  logic enable,
  input  logic clrStrobe,
  input  logic limPri,
  input  logic limSec,
  output logic faultPri,
  output logic faultSec
);
  ilimStrobe_t stb;
  logic [1:0]  faultVec;

  ilim_window_ctrl #(.WIN_LEN(WIN_LEN)) u_ctrl (
    .clk(clk), .rstN(rstN), .cycleEn(cycleEn), .enable(enable),
    .clrStrobe(clrStrobe), .stb(stb)
  );

  ilim_event_path #(.PRI_LIMIT(PRI_LIMIT), .SEC_LIMIT(SEC_LIMIT)) u_path (
    .clk(clk), .rstN(rstN), .stb(stb), .lim({limSec, limPri}), .fault(faultVec)
  );

  assign faultPri = faultVec[0];
  assign faultSec = faultVec[1];
endmodule

// File: rtl/ilim_window_checker.sv
module ilim_window_checker (
  input logic clk,
  input logic rstN,
  input logic cycleEn,
  input logic enable,
  input logic clrStrobe,
  input logic faultPri,
  input logic faultSec
);
  logic enD;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) enD <= 1'b0;
    else       enD <= enable;
  end

  assert_rise_on_tick_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(faultPri) |-> $past(cycleEn && enable && !clrStrobe));

  assert_rise_on_tick_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(faultSec) |-> $past(cycleEn && enable && !clrStrobe));

  assert_clear_wins_R8: assert property (@(posedge clk) disable iff (!rstN)
    clrStrobe |=> (!faultPri && !faultSec));

  assert_enable_rise_clears_R6: assert property (@(posedge clk) disable iff (!rstN)
    (enable && !enD) |=> (!faultPri && !faultSec));

  assert_fault_latched_R6: assert property (@(posedge clk) disable iff (!rstN)
    (faultPri && !clrStrobe && !(enable && !enD)) |=> faultPri);

  assert_idle_holds_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!enable && !clrStrobe) |=> ($stable(faultPri) && $stable(faultSec)));
endmodule

bind ilim_window_monitor ilim_window_checker u_chk (
  .clk(clk), .rstN(rstN), .cycleEn(cycleEn), .enable(enable),
  .clrStrobe(clrStrobe), .faultPri(faultPri), .faultSec(faultSec)
);

// File: tb/ilim_window_monitor_tb.sv
module ilim_window_monitor_tb;
  localparam int WIN = 32;
  localparam int LP  = 4;
  localparam int LS  = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cycleEn = 1'b0, enable = 1'b0, clrStrobe = 1'b0;
  logic limPri = 1'b0, limSec = 1'b0;
  logic faultPri, faultSec;

  int nChecks = 0;
  int nFail = 0;

  // behavioural expectation state
  bit mPrev[2], mSeen[2], mFault[2];
  int mCnt[2];
  int mWin = 0;
  bit mEnQ = 0;

  always #10 clk = ~clk;

  ilim_window_monitor #(.WIN_LEN(WIN), .PRI_LIMIT(LP), .SEC_LIMIT(LS)) u_dut (
    .clk(clk), .rstN(rstN), .cycleEn(cycleEn), .enable(enable),
    .clrStrobe(clrStrobe), .limPri(limPri), .limSec(limSec),
    .faultPri(faultPri), .faultSec(faultSec)
  );

  function automatic int limOf(input int s);
    return (s == 0) ? LP : LS;
  endfunction

  task automatic modelStep();
    bit tick, flush, fclr, winEnd, edgeNow, hit;
    bit lv;
    int nxt;
    tick   = cycleEn && enable;
    flush  = !enable || clrStrobe;
    fclr   = clrStrobe || (enable && !mEnQ);
    winEnd = tick && (mWin == WIN - 1);
    for (int s = 0; s < 2; s++) begin
      lv = (s == 0) ? limPri : limSec;
      edgeNow = lv && !mPrev[s];
      hit = mSeen[s] || edgeNow;
      nxt = mCnt[s] + (hit ? 1 : 0);
      if (fclr) mFault[s] = 0;
      else if (tick && nxt >= limOf(s)) mFault[s] = 1;
      if (flush) begin mSeen[s] = 0; mCnt[s] = 0; end
      else if (tick) begin
        mSeen[s] = 0;
        mCnt[s] = winEnd ? 0 : ((nxt > limOf(s)) ? limOf(s) : nxt);
      end else if (edgeNow) mSeen[s] = 1;
      mPrev[s] = lv;
    end
    if (flush) mWin = 0;
    else if (tick) mWin = winEnd ? 0 : mWin + 1;
    mEnQ = enable;
  endtask

  task automatic chk(input string tag, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic clk1(input bit ce, input bit p, input bit s, input string tag);
    cycleEn = ce; limPri = p; limSec = s;
    @(posedge clk);
    modelStep();
    @(negedge clk);
    chk({tag, " pri"}, faultPri, mFault[0]);
    chk({tag, " sec"}, faultSec, mFault[1]);
  endtask

  // one switching cycle of four clocks, pulses in the first clock
  task automatic pulseCycle(input bit p, input bit s, input string tag);
    clk1(1'b0, p, s, tag);
    clk1(1'b0, 1'b0, 1'b0, tag);
    clk1(1'b0, 1'b0, 1'b0, tag);
    clk1(1'b1, 1'b0, 1'b0, tag);
  endtask

  task automatic doClear(input string tag);
    clrStrobe = 1'b1;
    clk1(1'b0, 1'b0, 1'b0, tag);
    clrStrobe = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", nChecks + 1 - nFail, nChecks + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R9 reset pri", faultPri, 1'b0);
    chk("R9 reset sec", faultSec, 1'b0);

    enable = 1'b1;
    // R2: four primary events in one window
    for (int i = 0; i < 3; i++) pulseCycle(1, 0, "R2");
    chk("R2 three events", faultPri, 1'b0);
    pulseCycle(1, 0, "R2");
    chk("R2 fourth event", faultPri, 1'b1);
    chk("R3 untouched by primary", faultSec, 1'b0);

    // R8: clear
    doClear("R8");
    chk("R8 clear pri", faultPri, 1'b0);

    // R1: events split across a window boundary
    for (int i = 0; i < WIN - 3; i++) pulseCycle(0, 0, "R1");
    for (int i = 0; i < 3; i++) pulseCycle(1, 0, "R1");
    pulseCycle(1, 0, "R1");
    chk("R1 window restart", faultPri, 1'b0);

    // R4: level held high counts once, several pulses in one cycle count once
    doClear("R4");
    limPri = 1'b1;
    for (int i = 0; i < 12; i++) clk1((i % 4) == 3, 1'b1, 1'b0, "R4");
    for (int c = 0; c < 2; c++)
      for (int i = 0; i < 6; i++) clk1(i == 5, (i % 2) == 0, 1'b0, "R4");
    chk("R4 count once per cycle", faultPri, 1'b0);
    for (int i = 0; i < 4; i++) clk1(i == 3, i == 3, 1'b0, "R4");
    chk("R4 edge on strobe clock", faultPri, 1'b1);

    // R3: secondary threshold
    doClear("R3");
    for (int i = 0; i < 7; i++) pulseCycle(0, 1, "R3");
    chk("R3 seven events", faultSec, 1'b0);
    pulseCycle(0, 1, "R3");
    chk("R3 eighth event", faultSec, 1'b1);
    chk("R3 primary stays", faultPri, 1'b0);

    // R5: both thresholds at the same strobe
    doClear("R5");
    for (int i = 0; i < 4; i++) pulseCycle(0, 1, "R5");
    for (int i = 0; i < 3; i++) pulseCycle(1, 1, "R5");
    chk("R5 before pri", faultPri, 1'b0);
    chk("R5 before sec", faultSec, 1'b0);
    pulseCycle(1, 1, "R5");
    chk("R5 both pri", faultPri, 1'b1);
    chk("R5 both sec", faultSec, 1'b1);

    // R6/R7: latched while disabled, events ignored, enable rise clears
    enable = 1'b0;
    for (int i = 0; i < 10; i++) pulseCycle(1, 1, "R7");
    chk("R6 latched pri", faultPri, 1'b1);
    chk("R6 latched sec", faultSec, 1'b1);
    enable = 1'b1;
    clk1(1'b0, 1'b0, 1'b0, "R6");
    chk("R6 enable rise pri", faultPri, 1'b0);
    chk("R6 enable rise sec", faultSec, 1'b0);
    for (int i = 0; i < 3; i++) pulseCycle(1, 0, "R7");
    chk("R7 nothing carried over", faultPri, 1'b0);
    pulseCycle(1, 0, "R7");
    chk("R7 counting resumes", faultPri, 1'b1);

    // R8: clear in same clock as threshold strobe
    doClear("R8");
    for (int i = 0; i < 3; i++) pulseCycle(1, 0, "R8");
    clk1(1'b0, 1'b1, 1'b0, "R8");
    clrStrobe = 1'b1;
    clk1(1'b1, 1'b0, 1'b0, "R8");
    clrStrobe = 1'b0;
    chk("R8 clear beats set", faultPri, 1'b0);

    // random mix checked every clock against the expectation state
    for (int i = 0; i < 6000; i++) begin
      if (($urandom % 400) == 0) enable = ~enable;
      clrStrobe = (($urandom % 300) == 0);
      clk1(($urandom % 4) == 0, ($urandom % 5) == 0, ($urandom % 3) == 0, "R1 random");
    end
    clrStrobe = 1'b0;

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule